// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds a processor core's sixteen 32-bit general registers and a 32-bit saved-status word. It also holds the shadow copies that let each privilege mode keep its own stack pointer, link register and saved status. The surrounding core asks for a new mode by raising a one-cycle strobe with a mode code. On that clock edge the block stores the outgoing mode's banked values and brings in the incoming mode's values. The whole exchange completes in that single edge, so the block has no busy phase.

Each of the five exception-style modes has its own bank. User and system modes share one unbanked set. Registers 8 to 12 have only two copies: one for the fast-interrupt mode and one shared by every other mode. They are exchanged only when the fast-interrupt mode is entered or left. Two combinational read ports, one write port and a saved-status write port give the core its normal access to the live view.

Top module: `mode_bank_regfile`

## Requirements
- R1: After reset all sixteen registers read 0, the saved-status output is 0, the current mode is system (code 1), and every shadow slot holds 0.
- R2: The mode codes are 0 user, 1 system, 2 fast interrupt, 3 interrupt, 4 supervisor, 5 abort and 6 undefined. A valid code presented with the change strobe becomes the current mode on the next clock edge.
- R3: Mode code 7 is not a mode. A request carrying it leaves the current mode, the registers and the saved status unchanged.
- R4: A request for the mode already in force changes no register and no saved status.
- R5: Moving between user and system swaps nothing. Registers 13 and 14 and the saved status keep their live values.
- R6: When the old and new banks differ, registers 13 and 14 are stored into the old bank's slots and loaded from the new bank's slots. Returning to a mode restores the values it had when it was left.
- R7: The saved-status word is banked in the same way as registers 13 and 14.
- R8: Registers 8 to 12 are exchanged only when the old or the new mode is fast interrupt. The fast mode has its own set, and all other modes share a second set. A change between two non-fast banks leaves registers 8 to 12 unchanged.
- R9: Registers 0 to 7 and 15 are never affected by a mode change.
- R10: A register write or saved-status write issued in the same cycle as a mode change lands in the new mode's view. The old bank keeps the value from before the write.
- R11: Both read ports return the live register selected by their address combinationally. A write becomes visible after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeReq | input | 3 | Requested mode code |
| modeChg | input | 1 | Mode change strobe |
| rdAddrA | input | 4 | Read port A register index |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B register index |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 4 | Register write index |
| wrData | input | 32 | Register write data |
| statusWrEn | input | 1 | Saved-status write enable |
| statusWrData | input | 32 | Saved-status write data |
| savedStatus | output | 32 | Live saved-status word |
| curMode | output | 3 | Current mode code |

## Verification
On every cycle, the assertions check the mode register and the control strobes. They check that an accepted code becomes the mode, that code 7 and same-mode requests cause no swap, and that moves within the user and system pair cause no swap. They also check that the high-register exchange never occurs without a bank change, and that the saved status holds when neither a swap nor a write occurs. Whether the right values travel into and out of the right shadow slots can only be shown by the bench's scenarios. These scenarios round-trip values through several banks and through both copies of registers 8 to 12. They also cover the ordering of a write issued in the same cycle as a mode change.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 16;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int MODE_W    = 3;
  localparam int NUM_BANKS = 6;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;
  localparam int HI_FIRST  = 8;
  localparam int HI_COUNT  = 5;

  typedef enum logic [MODE_W-1:0] {
    MD_USER = 3'd0, MD_SYS = 3'd1, MD_FAST = 3'd2, MD_INT = 3'd3,
    MD_SVC  = 3'd4, MD_ABT = 3'd5, MD_UND  = 3'd6, MD_BAD = 3'd7
  } mode_e;

  typedef enum logic [BANK_W-1:0] {
    BK_NONE = 3'd0, BK_FAST = 3'd1, BK_INT = 3'd2,
    BK_SVC  = 3'd3, BK_ABT  = 3'd4, BK_UND = 3'd5
  } bank_e;

  typedef struct packed {
    logic              swap;
    logic              hiSwap;
    logic [BANK_W-1:0] oldBank;
    logic [BANK_W-1:0] newBank;
    logic              oldFast;
    logic              newFast;
  } swap_stb_t;

  function automatic bank_e bankOf(logic [MODE_W-1:0] m);
    case (m)
      MD_FAST: bankOf = BK_FAST;
      MD_INT:  bankOf = BK_INT;
      MD_SVC:  bankOf = BK_SVC;
      MD_ABT:  bankOf = BK_ABT;
      MD_UND:  bankOf = BK_UND;
      default: bankOf = BK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mrf_ctrl.sv
module mrf_ctrl
  import mrf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeReq,
  input  logic              modeChg,
  output logic [MODE_W-1:0] curMode,
  output swap_stb_t         stb
);
  logic  accept;
  bank_e oldB, newB;

  assign oldB   = bankOf(curMode);
  assign newB   = bankOf(modeReq);
  assign accept = modeChg && (modeReq != curMode) && (modeReq != MD_BAD);

  always_comb begin
    stb.oldBank = oldB;
    stb.newBank = newB;
    stb.oldFast = (oldB == BK_FAST);
    stb.newFast = (newB == BK_FAST);
    stb.swap    = accept && (oldB != newB);
    stb.hiSwap  = accept && (oldB != newB) && ((oldB == BK_FAST) || (newB == BK_FAST));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       curMode <= MD_SYS;
    else if (accept) curMode <= modeReq;
  end
endmodule

// File: rtl/mrf_dpath.sv
module mrf_dpath
  import mrf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  swap_stb_t         stb,
  input  logic [IDX_W-1:0]  rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statusWrEn,
  input  logic [DATA_W-1:0] statusWrData,
  output logic [DATA_W-1:0] savedStatus
);
  logic [DATA_W-1:0] gpr      [NUM_REGS];
  logic [DATA_W-1:0] nextGpr  [NUM_REGS];
  logic [DATA_W-1:0] bankSp   [NUM_BANKS];
  logic [DATA_W-1:0] bankLr   [NUM_BANKS];
  logic [DATA_W-1:0] bankStat [NUM_BANKS];
  logic [DATA_W-1:0] hiSet    [2][HI_COUNT];
  logic [DATA_W-1:0] liveStat, nextStat;

  assign rdDataA     = gpr[rdAddrA];
  assign rdDataB     = gpr[rdAddrB];
  assign savedStatus = liveStat;

  // Incoming view first, then any same-cycle write on top of it.
  always_comb begin
    nextGpr = gpr;
    if (stb.hiSwap)
      for (int i = 0; i < HI_COUNT; i++) nextGpr[HI_FIRST+i] = hiSet[stb.newFast][i];
    if (stb.swap) begin
      nextGpr[SP_IDX] = bankSp[stb.newBank];
      nextGpr[LR_IDX] = bankLr[stb.newBank];
    end
    if (wrEn) nextGpr[wrAddr] = wrData;
    nextStat = stb.swap ? bankStat[stb.newBank] : liveStat;
    if (statusWrEn) nextStat = statusWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) gpr[i] <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        bankSp[b]   <= '0;
        bankLr[b]   <= '0;
        bankStat[b] <= '0;
      end
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < HI_COUNT; i++) hiSet[s][i] <= '0;
      liveStat <= '0;
    end else begin
      if (stb.swap) begin
        bankSp[stb.oldBank]   <= gpr[SP_IDX];
        bankLr[stb.oldBank]   <= gpr[LR_IDX];
        bankStat[stb.oldBank] <= liveStat;
      end
      if (stb.hiSwap)
        for (int i = 0; i < HI_COUNT; i++) hiSet[stb.oldFast][i] <= gpr[HI_FIRST+i];
      gpr      <= nextGpr;
      liveStat <= nextStat;
    end
  end
endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
  import mrf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeReq,
  input  logic              modeChg,
  input  logic [IDX_W-1:0]  rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statusWrEn,
  input  logic [DATA_W-1:0] statusWrData,
  output logic [DATA_W-1:0] savedStatus,
  output logic [MODE_W-1:0] curMode
);
  swap_stb_t ctrlStb;

  mrf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .modeChg(modeChg),
    .curMode(curMode), .stb(ctrlStb)
  );

  mrf_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(ctrlStb),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData), .savedStatus(savedStatus)
  );
endmodule

// File: rtl/mrf_chk.sv
module mrf_chk
  import mrf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] modeReq,
  input logic              modeChg,
  input logic [MODE_W-1:0] curMode,
  input logic              statusWrEn,
  input logic [DATA_W-1:0] savedStatus,
  input logic              swapStb,
  input logic              hiStb
);
  // R2
  mode_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeChg && modeReq != 3'd7) |=> (curMode == $past(modeReq)));
  // R3
  bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeChg && modeReq == 3'd7) |=> $stable(curMode));
  // R3
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    curMode != 3'd7);
  // R4
  same_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeChg && modeReq == curMode) |-> !swapStb);
  // R5
  unbanked_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeChg && modeReq <= 3'd1 && curMode <= 3'd1) |-> !swapStb);
  // R8
  hi_needs_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiStb |-> swapStb);
  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!swapStb && !statusWrEn) |=> $stable(savedStatus));
endmodule

bind mode_bank_regfile mrf_chk u_chk (
  .clk(clk), .rstN(rstN), .modeReq(modeReq), .modeChg(modeChg),
  .curMode(curMode), .statusWrEn(statusWrEn), .savedStatus(savedStatus),
  .swapStb(ctrlStb.swap), .hiStb(ctrlStb.hiSwap)
);

// File: tb/mode_bank_regfile_tb.sv
module mode_bank_regfile_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [2:0]  modeReq = '0;
  logic        modeChg = 0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, statusWrData = '0, savedStatus;
  logic        wrEn = 0, statusWrEn = 0;
  logic [2:0]  curMode;
  int nTests = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mode_bank_regfile u_dut (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .modeChg(modeChg),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .savedStatus(savedStatus), .curMode(curMode)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, int a, logic [31:0] exp);
    rdAddrA = 4'(a);
    #1;
    chk(tag, rdDataA, exp);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic wrStat(logic [31:0] d);
    @(negedge clk);
    statusWrEn = 1; statusWrData = d;
    @(negedge clk);
    statusWrEn = 0;
  endtask

  task automatic goMode(int m);
    @(negedge clk);
    modeReq = 3'(m); modeChg = 1;
    @(negedge clk);
    modeChg = 0;
  endtask

  task automatic t_reset;
    chk("R1 mode", 32'(curMode), 32'd1);
    chk("R1 status", savedStatus, 32'd0);
    for (int i = 0; i < 16; i++) begin
      rdAddrB = 4'(15 - i);
      rd("R1 reg", i, 32'd0);
      chk("R1 regB", rdDataB, 32'd0);
    end
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++) wr(i, 32'h100 + i);
    for (int i = 0; i < 16; i++) begin
      rdAddrB = 4'(i);
      rd("R11 portA", i, 32'h100 + i);
      chk("R11 portB", rdDataB, 32'h100 + i);
    end
    wrStat(32'hAAA);
    chk("R11 status", savedStatus, 32'hAAA);
  endtask

  task automatic t_userSys;
    goMode(0);
    chk("R2 user", 32'(curMode), 32'd0);
    rd("R5 r13", 13, 32'h10D);
    rd("R5 r14", 14, 32'h10E);
    chk("R5 status", savedStatus, 32'hAAA);
    goMode(1);
    chk("R2 sys", 32'(curMode), 32'd1);
    rd("R5 r13 back", 13, 32'h10D);
  endtask

  task automatic t_banks;
    goMode(3);
    chk("R2 int", 32'(curMode), 32'd3);
    rd("R6 r13 new", 13, 32'h0);
    rd("R6 r14 new", 14, 32'h0);
    chk("R7 status new", savedStatus, 32'h0);
    rd("R8 r8 kept", 8, 32'h108);
    rd("R8 r12 kept", 12, 32'h10C);
    rd("R9 r0", 0, 32'h100);
    rd("R9 r15", 15, 32'h10F);
    wr(13, 32'h2013); wr(14, 32'h2014); wrStat(32'h2222);
    goMode(4);
    rd("R6 svc r13", 13, 32'h0);
    chk("R7 svc status", savedStatus, 32'h0);
    rd("R8 svc r9", 9, 32'h109);
    goMode(3);
    rd("R6 int restore r13", 13, 32'h2013);
    rd("R6 int restore r14", 14, 32'h2014);
    chk("R7 int restore", savedStatus, 32'h2222);
    goMode(6);
    rd("R6 und r13", 13, 32'h0);
    goMode(1);
    rd("R6 sys r13", 13, 32'h10D);
    rd("R6 sys r14", 14, 32'h10E);
    chk("R7 sys status", savedStatus, 32'hAAA);
  endtask

  task automatic t_fast;
    goMode(2);
    for (int i = 8; i <= 12; i++) rd("R8 fast empty", i, 32'h0);
    rd("R6 fast r13", 13, 32'h0);
    rd("R9 fast r7", 7, 32'h107);
    for (int i = 8; i <= 12; i++) wr(i, 32'hF00 + i);
    goMode(3);
    for (int i = 8; i <= 12; i++) rd("R8 shared restore", i, 32'h100 + i);
    rd("R6 int r13", 13, 32'h2013);
    goMode(2);
    for (int i = 8; i <= 12; i++) rd("R8 fast restore", i, 32'hF00 + i);
    goMode(1);
    rd("R8 sys r10", 10, 32'h10A);
  endtask

  task automatic t_noops;
    goMode(1);
    chk("R4 mode", 32'(curMode), 32'd1);
    rd("R4 r13", 13, 32'h10D);
    rd("R4 r8", 8, 32'h108);
    chk("R4 status", savedStatus, 32'hAAA);
    goMode(7);
    chk("R3 mode", 32'(curMode), 32'd1);
    rd("R3 r13", 13, 32'h10D);
    rd("R3 r9", 9, 32'h109);
    chk("R3 status", savedStatus, 32'hAAA);
  endtask

  task automatic t_sameCycle;
    @(negedge clk);
    modeReq = 3'd5; modeChg = 1;
    wrEn = 1; wrAddr = 4'd13; wrData = 32'h5555;
    statusWrEn = 1; statusWrData = 32'h5A5A;
    @(negedge clk);
    modeChg = 0; wrEn = 0; statusWrEn = 0;
    chk("R10 mode", 32'(curMode), 32'd5);
    rd("R10 new r13", 13, 32'h5555);
    chk("R10 new status", savedStatus, 32'h5A5A);
    goMode(1);
    rd("R10 old r13", 13, 32'h10D);
    chk("R10 old status", savedStatus, 32'hAAA);
    goMode(5);
    rd("R10 abt r13", 13, 32'h5555);
    goMode(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_userSys();
    t_banks();
    t_fast();
    t_noops();
    t_sameCycle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule